// File: doc/BRIEF.md
# FIFO-Paced Stereo Tone Bus Master

This block is a bus master that keeps a stereo audio output interface supplied with a sine tone. The audio interface sits on a memory-mapped bus. It holds a left and a right sample FIFO and one status word that reports the free space in each FIFO. The master first reads that status word. When there is space, it takes the next sample from a phase-accumulator oscillator. It then writes the sample to the left FIFO and afterwards to the right FIFO. It waits for the bus acknowledge after every transfer.

New samples are produced only when the FIFOs have space. The tone therefore advances at exactly the rate the interface drains the FIFOs (48 kHz in the intended system), and the block needs no timer of its own. The pitch is set by a 32-bit phase increment. A left-only mode lets the block fill just the left FIFO, so that another master can own the right channel.

The most recent left free-space count is brought out for display. A synchronous reset zeroes the phase and returns the block to the status read.

Top module: `tone_feed_master`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, the block requests a read (`bus_read`=1, `bus_write`=0) at status address 0, and `left_room` is 0. Reset also sets the oscillator phase to 0.
- R2: A request (read or write) and its address stay unchanged until the cycle in which `bus_ack` is 1, and that cycle completes the transfer. A read and a write are never requested together.
- R3: One cycle after a status read completes, `left_room` equals bits 31:24 of the read data. It keeps that value until the next status read completes.
- R4: In normal mode there is room only when both the left field (status bits 31:24) and the right field (status bits 23:16) are nonzero. With no room, the next request is another status read and the phase does not advance.
- R5: After a status read that finds room in normal mode, the block writes the sample to address 2 (left FIFO), then writes the same sample to address 3 (right FIFO), then reads the status again.
- R6: A written sample is the sine table entry at phase bits 31:24, sign-extended to 32 bits. The table holds 256 entries: for index k < 128, with p = k·(128−k), the value is 32767·16·p / (81920 − 4·p), truncated toward zero. For k ≥ 128 the value is the negative of the value at k−128. After each generated sample the phase advances by `phase_step`, so the first sample after reset uses index 0.
- R7: In left-only mode there is room when the left field alone is nonzero, and the right field is ignored. Only the left write at address 2 is made, and address 3 is never written.
- R8: The mode is taken from `left_only` at the moment a status read completes. That sample then finishes in that mode, even if `left_only` changes before its writes are done.
- R9: The phase wraps modulo 2^32. A step of 0xC0000000 from reset gives the sample sequence 0, −32767, 0, 32767, 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| left_only | input | 1 | 1 = fill the left FIFO only |
| phase_step | input | 32 | Phase increment per generated sample |
| bus_addr | output | 4 | Word address of the current request |
| bus_read | output | 1 | Read request (status word) |
| bus_write | output | 1 | Write request (FIFO sample) |
| bus_wdata | output | 32 | Sign-extended sample being written |
| bus_rdata | input | 32 | Read data; status carries left room in 31:24 and right room in 23:16 |
| bus_ack | input | 1 | Transfer complete this cycle |
| left_room | output | 8 | Left free-space count from the latest status read |

## Verification
A corrupted phase or sample register is caught at the next completed write. That write carries a value that differs from the bench's own table and phase model, so the error shows within one sample period. A state register that goes wrong shows up on the very next request as a wrong address or a wrong read/write strobe. Examples are a right write in left-only mode, a missing right write, or a write without room, and the scoreboard reports any of these when it pops its queue. A bad latch of the room field appears on `left_room` one cycle after the status acknowledge.

// File: rtl/tone_pkg.sv
`timescale 1ns/1ps
package tone_pkg;
  localparam int BUS_W     = 32;
  localparam int ROOM_W    = 8;
  localparam int LEFT_LSB  = BUS_W - ROOM_W;
  localparam int RIGHT_LSB = BUS_W - 2 * ROOM_W;

  typedef enum logic [1:0] {
    ST_POLL  = 2'd0,
    ST_LEFT  = 2'd1,
    ST_RIGHT = 2'd2
  } feed_state_t;

  // Sine value for one table slot: rational approximation over a half period.
  function automatic int sine_entry(input int idx, input int table_bits, input int sample_w);
    longint half_n, k, p, amp, num, den, v;
    half_n = longint'(1) << (table_bits - 1);
    amp    = (longint'(1) << (sample_w - 1)) - 1;
    k      = longint'(idx) % half_n;
    p      = k * (half_n - k);
    num    = amp * 16 * p;
    den    = 5 * half_n * half_n - 4 * p;
    v      = num / den;
    if (longint'(idx) >= half_n) v = -v;
    return int'(v);
  endfunction

  function automatic logic [ROOM_W-1:0] left_field(input logic [BUS_W-1:0] status);
    return status[LEFT_LSB +: ROOM_W];
  endfunction

  function automatic logic [ROOM_W-1:0] right_field(input logic [BUS_W-1:0] status);
    return status[RIGHT_LSB +: ROOM_W];
  endfunction

  // Room decision: left alone in single-channel mode, both otherwise.
  function automatic logic has_room(input logic [BUS_W-1:0] status, input logic single);
    logic l_ok, r_ok;
    l_ok = |left_field(status);
    r_ok = |right_field(status);
    return single ? l_ok : (l_ok && r_ok);
  endfunction
endpackage

// File: rtl/tone_sine_rom.sv
`timescale 1ns/1ps
module tone_sine_rom import tone_pkg::*; #(
  parameter int TABLE_BITS = 8,
  parameter int SAMPLE_W   = 16
) (
  input  logic [TABLE_BITS-1:0]      idx,
  output logic signed [SAMPLE_W-1:0] value
);
  localparam int DEPTH = 1 << TABLE_BITS;

  logic signed [SAMPLE_W-1:0] rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    localparam int SLOT_VAL = sine_entry(g, TABLE_BITS, SAMPLE_W);
    assign rom[g] = SAMPLE_W'(SLOT_VAL);
  end

  assign value = rom[idx];
endmodule

// File: rtl/tone_phase_acc.sv
`timescale 1ns/1ps
module tone_phase_acc #(
  parameter int PHASE_W    = 32,
  parameter int TABLE_BITS = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  advance,
  input  logic [PHASE_W-1:0]    step,
  output logic [TABLE_BITS-1:0] table_idx
);
  logic [PHASE_W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= '0;
    else if (advance) phase_q <= phase_q + step;
  end

  assign table_idx = phase_q[PHASE_W-1 -: TABLE_BITS];

  // R4: no advance means the phase holds
  assert_phase_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(phase_q));

  // R1: reset clears the phase
  assert_phase_reset_R1: assert property (@(posedge clk)
    rst |=> (phase_q == '0));
endmodule

// File: rtl/tone_bus_fsm.sv
`timescale 1ns/1ps
module tone_bus_fsm import tone_pkg::*; #(
  parameter int ADDR_W      = 4,
  parameter int SAMPLE_W    = 16,
  parameter int STATUS_ADDR = 0,
  parameter int LEFT_ADDR   = 2,
  parameter int RIGHT_ADDR  = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       left_only,
  input  logic                       bus_ack,
  input  logic [BUS_W-1:0]           bus_rdata,
  input  logic signed [SAMPLE_W-1:0] sample_in,
  output logic [ADDR_W-1:0]          bus_addr,
  output logic                       bus_read,
  output logic                       bus_write,
  output logic [BUS_W-1:0]           bus_wdata,
  output logic                       advance,
  output logic [ROOM_W-1:0]          left_room
);
  localparam int EXT_W = BUS_W - SAMPLE_W;

  feed_state_t                state_q, state_d;
  logic                       mode_lo_q;
  logic signed [SAMPLE_W-1:0] sample_q;
  logic [ROOM_W-1:0]          room_q;

  // named internal events
  logic status_done, left_done, right_done, room_ok;
  assign status_done = (state_q == ST_POLL)  && bus_ack;
  assign left_done   = (state_q == ST_LEFT)  && bus_ack;
  assign right_done  = (state_q == ST_RIGHT) && bus_ack;
  assign room_ok     = has_room(bus_rdata, left_only);
  assign advance     = status_done && room_ok;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_POLL:  if (advance) state_d = ST_LEFT;
      ST_LEFT:  if (left_done) state_d = mode_lo_q ? ST_POLL : ST_RIGHT;
      ST_RIGHT: if (right_done) state_d = ST_POLL;
      default:  state_d = ST_POLL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_POLL;
      mode_lo_q <= 1'b0;
      sample_q  <= '0;
      room_q    <= '0;
    end else begin
      state_q <= state_d;
      if (status_done) begin
        room_q    <= left_field(bus_rdata);
        mode_lo_q <= left_only;
      end
      if (advance) sample_q <= sample_in;
    end
  end

  always_comb begin
    bus_read  = (state_q == ST_POLL);
    bus_write = (state_q == ST_LEFT) || (state_q == ST_RIGHT);
    case (state_q)
      ST_LEFT:  bus_addr = ADDR_W'(LEFT_ADDR);
      ST_RIGHT: bus_addr = ADDR_W'(RIGHT_ADDR);
      default:  bus_addr = ADDR_W'(STATUS_ADDR);
    endcase
  end

  assign bus_wdata = {{EXT_W{sample_q[SAMPLE_W-1]}}, sample_q};
  assign left_room = room_q;

  // R2: never both strobes
  assert_single_request_R2: assert property (@(posedge clk) disable iff (rst)
    !(bus_read && bus_write));

  // R2: request held until acknowledged
  assert_request_hold_R2: assert property (@(posedge clk) disable iff (rst)
    ((bus_read || bus_write) && !bus_ack) |=>
      ($stable(bus_addr) && $stable(bus_read) && $stable(bus_write)));

  // R3: room field captured from the status word
  assert_room_latch_R3: assert property (@(posedge clk) disable iff (rst)
    status_done |=> (left_room == $past(bus_rdata[LEFT_LSB +: ROOM_W])));

  // R4: no room leads back to a status read
  assert_noroom_repoll_R4: assert property (@(posedge clk) disable iff (rst)
    (status_done && !room_ok) |=> (bus_read && bus_addr == ADDR_W'(STATUS_ADDR)));

  // R5: right write follows left write in stereo mode
  assert_right_follows_R5: assert property (@(posedge clk) disable iff (rst)
    (left_done && !mode_lo_q) |=> (bus_write && bus_addr == ADDR_W'(RIGHT_ADDR)));

  // R7: single-channel sample never touches the right FIFO
  assert_lo_no_right_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_write && bus_addr == ADDR_W'(RIGHT_ADDR)) |-> !mode_lo_q);
endmodule

// File: rtl/tone_feed_master.sv
`timescale 1ns/1ps
module tone_feed_master import tone_pkg::*; #(
  parameter int PHASE_W     = 32,
  parameter int TABLE_BITS  = 8,
  parameter int SAMPLE_W    = 16,
  parameter int ADDR_W      = 4,
  parameter int STATUS_ADDR = 0,
  parameter int LEFT_ADDR   = 2,
  parameter int RIGHT_ADDR  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               left_only,
  input  logic [PHASE_W-1:0] phase_step,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic               bus_read,
  output logic               bus_write,
  output logic [31:0]        bus_wdata,
  input  logic [31:0]        bus_rdata,
  input  logic               bus_ack,
  output logic [7:0]         left_room
);
  logic                       advance;
  logic [TABLE_BITS-1:0]      table_idx;
  logic signed [SAMPLE_W-1:0] table_val;

  tone_phase_acc #(.PHASE_W(PHASE_W), .TABLE_BITS(TABLE_BITS)) u_phase (
    .clk(clk), .rst(rst), .advance(advance), .step(phase_step), .table_idx(table_idx)
  );

  tone_sine_rom #(.TABLE_BITS(TABLE_BITS), .SAMPLE_W(SAMPLE_W)) u_rom (
    .idx(table_idx), .value(table_val)
  );

  tone_bus_fsm #(
    .ADDR_W(ADDR_W), .SAMPLE_W(SAMPLE_W), .STATUS_ADDR(STATUS_ADDR),
    .LEFT_ADDR(LEFT_ADDR), .RIGHT_ADDR(RIGHT_ADDR)
  ) u_fsm (
    .clk(clk), .rst(rst), .left_only(left_only), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .sample_in(table_val), .bus_addr(bus_addr),
    .bus_read(bus_read), .bus_write(bus_write), .bus_wdata(bus_wdata),
    .advance(advance), .left_room(left_room)
  );

  // R1: reset state seen at the ports
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (bus_read && !bus_write && bus_addr == ADDR_W'(STATUS_ADDR) && left_room == 8'd0));
endmodule

// File: tb/tone_feed_master_bench.sv
`timescale 1ns/1ps
module tone_feed_master_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        left_only;
  logic [31:0] phase_step;
  logic [3:0]  bus_addr;
  logic        bus_read, bus_write;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_ack;
  logic [7:0]  left_room;

  int total = 0;
  int bad   = 0;

  // slave-side knobs
  int       lat = 0;
  int       wcnt;
  bit [7:0] lfree = 0, rfree = 0;

  // scoreboard state
  int          exp_addr[$];
  logic [31:0] exp_data[$];
  logic [31:0] seen_left[$];
  logic [31:0] ph_model;
  int wr_total = 0, right_total = 0, poll_total = 0;
  bit chk_room = 0;
  int room_exp;

  always #2 clk = ~clk;

  tone_feed_master u_tone_feed_master (
    .clk(clk), .rst(rst), .left_only(left_only), .phase_step(phase_step),
    .bus_addr(bus_addr), .bus_read(bus_read), .bus_write(bus_write),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .left_room(left_room)
  );

  assign bus_rdata = {lfree, rfree, 16'h0000};

  // independent restatement of the table in R6
  function automatic logic [31:0] ref_sine(input int k);
    int m;
    longint prod, top, bottom, mag;
    m      = k & 127;
    prod   = longint'(m) * longint'(128 - m);
    top    = 32767 * (prod << 4);
    bottom = 81920 - (prod << 2);
    mag    = top / bottom;
    return (k >= 128) ? 32'(-mag) : 32'(mag);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // bus slave: registered ack after lat wait cycles
  always @(posedge clk) begin
    if (rst) begin
      bus_ack <= 1'b0;
      wcnt    <= 0;
    end else if (bus_ack) begin
      bus_ack <= 1'b0;
      wcnt    <= 0;
    end else if (bus_read || bus_write) begin
      if (wcnt >= lat) bus_ack <= 1'b1;
      else wcnt <= wcnt + 1;
    end
  end

  // monitor / scoreboard, sampling away from the active edge
  always @(negedge clk) begin
    if (rst) begin
      ph_model = 32'h0;
      exp_addr.delete();
      exp_data.delete();
      chk_room = 0;
    end else begin
      if (chk_room) begin
        check(left_room == 8'(room_exp), "R3 left_room", left_room, room_exp);
        chk_room = 0;
      end
      if (bus_ack && bus_read) begin
        bit room;
        poll_total++;
        chk_room = 1;
        room_exp = lfree;
        room = left_only ? (lfree != 0) : (lfree != 0 && rfree != 0);
        if (room) begin
          logic [31:0] s;
          s = ref_sine(int'(ph_model[31:24]));
          exp_addr.push_back(2);
          exp_data.push_back(s);
          if (!left_only) begin
            exp_addr.push_back(3);
            exp_data.push_back(s);
          end
          ph_model = ph_model + phase_step;
        end
      end else if (bus_ack && bus_write) begin
        wr_total++;
        if (bus_addr == 4'd3) right_total++;
        if (bus_addr == 4'd2) seen_left.push_back(bus_wdata);
        if (exp_addr.size() == 0) begin
          check(1'b0, "R4/R7 unexpected write addr", bus_addr, -1);
        end else begin
          int          ea;
          logic [31:0] ed;
          ea = exp_addr.pop_front();
          ed = exp_data.pop_front();
          check(int'(bus_addr) == ea, "R5 write address", bus_addr, ea);
          check(bus_wdata == ed, "R6 sample value", $signed(bus_wdata), $signed(ed));
        end
      end
    end
  end

  task automatic wait_writes(input int n);
    int target;
    target = wr_total + n;
    while (wr_total < target) @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #600000;
    check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int w0, p0, r0, base;
    rst = 1'b1; left_only = 1'b0; phase_step = 32'h0; lfree = 0; rfree = 0; lat = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(bus_read == 1'b1, "R1 read during reset", bus_read, 1);
    check(bus_write == 1'b0, "R1 no write during reset", bus_write, 0);
    check(bus_addr == 4'd0, "R1 status address", bus_addr, 0);
    check(left_room == 8'd0, "R1 left_room cleared", left_room, 0);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    check(bus_read && bus_addr == 4'd0, "R1 read after release", {bus_read, bus_addr}, 16);

    // R4: no room at all, then R2 handshake under polling
    phase_step = 32'h0100_0000;
    idle(30);
    check(wr_total == 0, "R4 no write without room", wr_total, 0);
    check(poll_total > 5, "R4 repeated polling", poll_total, 6);

    // R5/R6: stereo writes, first sample from index 0
    lfree = 8'd10; rfree = 8'd10;
    wait_writes(16);
    check(seen_left.size() > 1 && seen_left[0] == 32'h0, "R6 first sample index 0", seen_left[0], 0);
    check(seen_left[1] == ref_sine(1), "R6 second sample index 1", seen_left[1], ref_sine(1));

    // R2: with wait cycles on every transfer
    lat = 3; phase_step = 32'h0258_BF26;
    wait_writes(12);

    // R4: right FIFO full in stereo mode
    rfree = 8'd0;
    idle(40);
    w0 = wr_total; p0 = poll_total;
    idle(40);
    check(wr_total == w0, "R4 right full blocks writes", wr_total - w0, 0);
    check(poll_total > p0, "R4 keeps polling", poll_total - p0, 1);

    // R7: left-only mode ignores right field
    left_only = 1'b1;
    r0 = right_total;
    wait_writes(6);
    check(right_total == r0, "R7 no right writes", right_total - r0, 0);
    lfree = 8'd0;
    idle(40);
    w0 = wr_total;
    idle(40);
    check(wr_total == w0, "R7 left full blocks writes", wr_total - w0, 0);

    // R8: mode change during a stereo sample
    left_only = 1'b0; lfree = 8'd5; rfree = 8'd5; lat = 2;
    @(negedge clk);
    while (!(bus_write && bus_addr == 4'd2)) @(negedge clk);
    r0 = right_total;
    @(posedge clk); #1 left_only = 1'b1;
    @(negedge clk);
    while (!bus_read) @(negedge clk);
    check(right_total == r0 + 1, "R8 sample finishes in latched mode", right_total - r0, 1);
    idle(20);

    // R9: wrap of the phase from reset
    rst = 1'b1; left_only = 1'b0; lat = 0;
    idle(3);
    phase_step = 32'hC000_0000;
    base = seen_left.size();
    rst = 1'b0;
    wait_writes(10);
    check(seen_left[base]     == 32'h0000_0000, "R9 sample 0", $signed(seen_left[base]), 0);
    check(seen_left[base + 1] == 32'hFFFF_8001, "R9 sample 1", $signed(seen_left[base + 1]), -32767);
    check(seen_left[base + 2] == 32'h0000_0000, "R9 sample 2", $signed(seen_left[base + 2]), 0);
    check(seen_left[base + 3] == 32'h0000_7FFF, "R9 sample 3", $signed(seen_left[base + 3]), 32767);
    check(seen_left[base + 4] == 32'h0000_0000, "R9 sample 4 wrapped", $signed(seen_left[base + 4]), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule